// File: doc/BRIEF.md
# SPI Serial EEPROM Command Decoder

This block is the serial front end of an EEPROM. It runs entirely on a fast system clock. Serial clock, chip select, hold and serial data arrive from the pads and are synchronised before use. Edges of the serial clock are detected in the system domain, so the system clock must run at least eight times faster than the serial clock. The block accepts only the two SPI modes whose clock idles at the same level it samples from: mode 0 and mode 3. It shifts in an opcode and, where the opcode needs them, a 16-bit address and data bytes. Serial output data is driven with a separate enable for the pad's tri-state buffer.

Six commands are decoded:

- **Latch set and latch clear** each raise a one-cycle strobe toward the status block.
- **Status read** shifts out a byte supplied by the status block.
- **Status write** delivers a byte to the status block with a strobe.
- **Read** streams bytes from an internal byte array and advances the address across the whole array.
- **Write** hands each received byte to the page-write path with its address. It also updates the internal array when the neighbouring protection logic grants the write.

Two conditions stop the block. An unrecognised opcode silences it until chip select falls again. A hold request taken while the serial clock is low freezes the transfer in place.

Top module: `spi_eeprom_front`

## Requirements
- R1: After reset, and whenever chip select is high, `spi_so_oe` is 0 and no command runs. A command starts only on a falling edge of chip select.
- R2: SI is captured on serial clock rising edges and `spi_so` changes only after falling edges. Every field is sent most significant bit first, and `spi_so_oe` is 1 while output data is being driven.
- R3: An opcode is valid only when its upper four bits are 0. Bit 3 is ignored. Low bits 110 raise `wel_set` for one cycle, and 100 raises `wel_clr` for one cycle.
- R4: Low bits 101 (status read) shift out `status_in`, starting on the falling edge after the opcode. `status_in` is re-sampled at each byte boundary while chip select stays low.
- R5: Low bits 001 (status write) take the next 8 bits and raise `sr_wr` for one cycle with that byte on `sr_wdata`.
- R6: Low bits 011 (read) are followed by a 16-bit address, of which only the low ADDR_W bits are used. Bytes stream from the array while chip select is low, and the address increments and wraps from the top address to 0.
- R7: Low bits 010 (write) are followed by a 16-bit address and data bytes. Each byte raises `pw_stb` for one cycle with `pw_addr` and `pw_data`, and the array takes the byte when `array_wr_ok` is 1.
- R8: During a write, only the low PAGE_W address bits advance after each byte. They wrap inside the page, so bytes beyond one page overwrite its start.
- R9: While `array_wr_ok` is 0, write bytes still strobe `pw_stb`, but the array content is left unchanged.
- R10: After an invalid opcode, further input in the same selection raises no strobe and `spi_so_oe` stays 0. The next chip-select fall decodes normally.
- R11: Hold taken low while the serial clock is low pauses the transfer. During the pause `spi_so_oe` is 0 and serial clock and SI activity is ignored. Hold raised while the serial clock is low resumes the transfer exactly where it stopped.
- R12: The strobes `wel_set`, `wel_clr`, `sr_wr` and `pw_stb` are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the pad |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Hold request, active low |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Output enable for the serial data out pad |
| status_in | input | 8 | Byte returned by status read |
| array_wr_ok | input | 1 | Grant for array update on write bytes |
| wel_set | output | 1 | Write-enable latch set strobe |
| wel_clr | output | 1 | Write-enable latch clear strobe |
| sr_wr | output | 1 | Status write strobe |
| sr_wdata | output | 8 | Status write byte |
| pw_stb | output | 1 | Write byte strobe |
| pw_addr | output | ADDR_W | Address of the write byte |
| pw_data | output | 8 | Write byte |

## Verification
The bench builds the block with ADDR_W = 6 and PAGE_W = 3. This gives a 64-byte array made of eight 8-byte pages.

That size lets the bench fill and read back every location. It can also run a single read burst past the top address and back to 0. Page overrun, the bit 3 and address don't-care bits, and a hold in the middle of a burst can then all be checked against a bench-side image of the array computed from the address arithmetic.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

   typedef enum logic [2:0] {
      CMD_SET, CMD_CLR, CMD_SRD, CMD_SWR, CMD_RD, CMD_WR, CMD_BAD
   } cmd_e;

   typedef enum logic [3:0] {
      ST_IDLE, ST_OPC, ST_ADDR, ST_RDATA, ST_WDATA,
      ST_SROUT, ST_SRIN, ST_DONE, ST_DEAD
   } state_e;

   function automatic cmd_e decode_op(input logic [7:0] op);
      if (op[7:4] != 4'h0) return CMD_BAD;
      case (op[2:0])
         3'b110:  return CMD_SET;
         3'b100:  return CMD_CLR;
         3'b101:  return CMD_SRD;
         3'b001:  return CMD_SWR;
         3'b011:  return CMD_RD;
         3'b010:  return CMD_WR;
         default: return CMD_BAD;
      endcase
   endfunction

endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
   parameter int WIDTH = 4,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q,
   output logic [WIDTH-1:0] q_prev
);
   logic [STAGES:0][WIDTH-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i <= STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg <= {stg[STAGES-1:0], d};
      end
   end

   assign q      = stg[STAGES-1];
   assign q_prev = stg[STAGES];
endmodule

// File: rtl/spi_ee_mem.sv
module spi_ee_mem #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/spi_ee_ctrl.sv
module spi_ee_ctrl
   import spi_ee_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int PAGE_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_lvl,
   input  logic              sck_rise,
   input  logic              sck_fall,
   input  logic              cs_lvl,
   input  logic              cs_fall,
   input  logic              hold_lvl,
   input  logic              si_lvl,
   input  logic [7:0]        status_in,
   input  logic [7:0]        rd_data,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              so_q,
   output logic              so_oe_q,
   output logic              en_set,
   output logic              en_clr,
   output logic              sr_wr,
   output logic [7:0]        sr_wdata,
   output logic              pw_stb,
   output logic [ADDR_W-1:0] pw_addr,
   output logic [7:0]        pw_data
);
   localparam logic [ADDR_W-1:0] A_ONE  = 1;
   localparam logic [PAGE_W-1:0] PG_ONE = 1;

   state_e            state;
   logic [3:0]        cnt;
   logic [7:0]        in_sh;
   logic [14:0]       addr_sh;
   logic [ADDR_W-1:0] addr_q;
   logic [7:0]        out_sh;
   logic              paused;
   logic              out_on;
   logic              is_wr;

   logic [7:0]        in_nxt;
   logic [15:0]       addr_full;
   logic              byte_end;
   logic              out_state;
   logic [PAGE_W-1:0] pg_inc;

   assign in_nxt    = {in_sh[6:0], si_lvl};
   assign addr_full = {addr_sh, si_lvl};
   assign byte_end  = (cnt[2:0] == 3'd7);
   assign out_state = (state == ST_SROUT) || (state == ST_RDATA);
   assign pg_inc    = addr_q[PAGE_W-1:0] + PG_ONE;

   always_comb begin
      if (state == ST_ADDR) rd_addr = addr_full[ADDR_W-1:0];
      else                  rd_addr = addr_q + A_ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         in_sh    <= '0;
         addr_sh  <= '0;
         addr_q   <= '0;
         out_sh   <= '0;
         paused   <= 1'b0;
         out_on   <= 1'b0;
         is_wr    <= 1'b0;
         so_q     <= 1'b0;
         so_oe_q  <= 1'b0;
         en_set   <= 1'b0;
         en_clr   <= 1'b0;
         sr_wr    <= 1'b0;
         sr_wdata <= '0;
         pw_stb   <= 1'b0;
         pw_addr  <= '0;
         pw_data  <= '0;
      end else begin
         en_set  <= 1'b0;
         en_clr  <= 1'b0;
         sr_wr   <= 1'b0;
         pw_stb  <= 1'b0;
         so_oe_q <= out_on && !paused && !cs_lvl && out_state;
         if (cs_lvl) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            paused <= 1'b0;
            out_on <= 1'b0;
         end else if (state == ST_IDLE) begin
            if (cs_fall) begin
               state <= ST_OPC;
               cnt   <= '0;
            end
         end else begin
            if (!sck_lvl) paused <= !hold_lvl;
            if (sck_rise && !paused) begin
               cnt <= cnt + 4'd1;
               case (state)
                  ST_OPC: begin
                     in_sh <= in_nxt;
                     if (byte_end) begin
                        cnt <= '0;
                        case (decode_op(in_nxt))
                           CMD_SET: begin en_set <= 1'b1; state <= ST_DONE; end
                           CMD_CLR: begin en_clr <= 1'b1; state <= ST_DONE; end
                           CMD_SRD: begin out_sh <= status_in; state <= ST_SROUT; end
                           CMD_SWR: state <= ST_SRIN;
                           CMD_RD:  begin is_wr <= 1'b0; state <= ST_ADDR; end
                           CMD_WR:  begin is_wr <= 1'b1; state <= ST_ADDR; end
                           default: state <= ST_DEAD;
                        endcase
                     end
                  end
                  ST_ADDR: begin
                     addr_sh <= addr_full[14:0];
                     if (cnt == 4'd15) begin
                        cnt    <= '0;
                        addr_q <= addr_full[ADDR_W-1:0];
                        if (is_wr) begin
                           state <= ST_WDATA;
                        end else begin
                           out_sh <= rd_data;
                           state  <= ST_RDATA;
                        end
                     end
                  end
                  ST_RDATA: begin
                     if (byte_end) begin
                        cnt    <= '0;
                        addr_q <= addr_q + A_ONE;
                        out_sh <= rd_data;
                     end
                  end
                  ST_SROUT: begin
                     if (byte_end) begin
                        cnt    <= '0;
                        out_sh <= status_in;
                     end
                  end
                  ST_SRIN: begin
                     in_sh <= in_nxt;
                     if (byte_end) begin
                        sr_wr    <= 1'b1;
                        sr_wdata <= in_nxt;
                        state    <= ST_DONE;
                     end
                  end
                  ST_WDATA: begin
                     in_sh <= in_nxt;
                     if (byte_end) begin
                        cnt     <= '0;
                        pw_stb  <= 1'b1;
                        pw_addr <= addr_q;
                        pw_data <= in_nxt;
                        addr_q  <= {addr_q[ADDR_W-1:PAGE_W], pg_inc};
                     end
                  end
                  default: ;
               endcase
            end else if (sck_fall && !paused && out_state) begin
               so_q   <= out_sh[7];
               out_sh <= {out_sh[6:0], 1'b0};
               out_on <= 1'b1;
            end
         end
      end
   end

   // R12
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({en_set, en_clr, sr_wr, pw_stb}));

   // R10
   dead_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DEAD) |-> !(en_set || en_clr || sr_wr || pw_stb || so_oe_q));

   // R11
   hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      paused |=> !so_oe_q);

   // R1
   cs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_lvl |=> !so_oe_q);

   // R2
   so_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sck_fall |=> $stable(so_q));

   // R7
   pw_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pw_stb |-> (state == ST_WDATA));

endmodule

// File: rtl/spi_eeprom_front.sv
module spi_eeprom_front #(
   parameter int ADDR_W      = 10,
   parameter int PAGE_W      = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sck,
   input  logic              spi_cs_n,
   input  logic              spi_si,
   input  logic              spi_hold_n,
   output logic              spi_so,
   output logic              spi_so_oe,
   input  logic [7:0]        status_in,
   input  logic              array_wr_ok,
   output logic              wel_set,
   output logic              wel_clr,
   output logic              sr_wr,
   output logic [7:0]        sr_wdata,
   output logic              pw_stb,
   output logic [ADDR_W-1:0] pw_addr,
   output logic [7:0]        pw_data
);
   localparam int PIN_W = 4;
   localparam int B_SCK = 3;
   localparam int B_CS  = 2;
   localparam int B_HLD = 1;
   localparam int B_SI  = 0;

   if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_addr
      $error("ADDR_W must lie in 2..16");
   end
   if (PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad_page
      $error("PAGE_W must lie in 1..ADDR_W-1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [PIN_W-1:0]  pin_q;
   logic [PIN_W-1:0]  pin_p;
   logic [ADDR_W-1:0] rd_addr;
   logic [7:0]        rd_data;

   spi_ee_sync #(
      .WIDTH  (PIN_W),
      .STAGES (SYNC_STAGES),
      .RST_VAL(4'b0110)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({spi_sck, spi_cs_n, spi_hold_n, spi_si}),
      .q     (pin_q),
      .q_prev(pin_p)
   );

   spi_ee_ctrl #(
      .ADDR_W(ADDR_W),
      .PAGE_W(PAGE_W)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .sck_lvl  (pin_q[B_SCK]),
      .sck_rise (pin_q[B_SCK] & ~pin_p[B_SCK]),
      .sck_fall (~pin_q[B_SCK] & pin_p[B_SCK]),
      .cs_lvl   (pin_q[B_CS]),
      .cs_fall  (~pin_q[B_CS] & pin_p[B_CS]),
      .hold_lvl (pin_q[B_HLD]),
      .si_lvl   (pin_q[B_SI]),
      .status_in(status_in),
      .rd_data  (rd_data),
      .rd_addr  (rd_addr),
      .so_q     (spi_so),
      .so_oe_q  (spi_so_oe),
      .en_set   (wel_set),
      .en_clr   (wel_clr),
      .sr_wr    (sr_wr),
      .sr_wdata (sr_wdata),
      .pw_stb   (pw_stb),
      .pw_addr  (pw_addr),
      .pw_data  (pw_data)
   );

   spi_ee_mem #(
      .ADDR_W(ADDR_W),
      .DATA_W(8)
   ) u_mem (
      .clk  (clk),
      .we   (pw_stb & array_wr_ok),
      .waddr(pw_addr),
      .wdata(pw_data),
      .raddr(rd_addr),
      .rdata(rd_data)
   );
endmodule

// File: tb/tb_spi_eeprom_front.sv
`timescale 1ns/1ps
module tb_spi_eeprom_front;
   localparam int AW = 6;
   localparam int PW = 3;
   localparam int DEPTH = 1 << AW;
   localparam int H = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
   logic so, so_oe;
   logic [7:0] status_in = 8'h00;
   logic wr_ok = 1'b1;
   logic wel_set, wel_clr, sr_wr, pw_stb;
   logic [7:0] sr_wdata, pw_data;
   logic [AW-1:0] pw_addr;

   int checks = 0, errors = 0;
   int n_set = 0, n_clr = 0, n_sr = 0, n_pw = 0;
   logic [7:0] last_sr = 8'h00;
   logic oe_seen = 1'b0;
   logic [7:0] exp_mem [DEPTH];

   always #2 clk = ~clk;

   spi_eeprom_front #(.ADDR_W(AW), .PAGE_W(PW), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
      .spi_hold_n(hold_n), .spi_so(so), .spi_so_oe(so_oe), .status_in(status_in),
      .array_wr_ok(wr_ok), .wel_set(wel_set), .wel_clr(wel_clr), .sr_wr(sr_wr),
      .sr_wdata(sr_wdata), .pw_stb(pw_stb), .pw_addr(pw_addr), .pw_data(pw_data)
   );

   always @(negedge clk) begin
      if (wel_set) n_set++;
      if (wel_clr) n_clr++;
      if (sr_wr) begin n_sr++; last_sr = sr_wdata; end
      if (pw_stb) n_pw++;
      if (so_oe) oe_seen = 1'b1;
   end

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
      for (int i = 7; i >= 0; i--) begin
         si = tx[i];
         wait_clk(H);
         rx[i] = so;
         sck = 1'b1;
         wait_clk(H);
         sck = 1'b0;
      end
   endtask

   task automatic cs_begin();
      cs_n = 1'b0;
      wait_clk(H);
   endtask

   task automatic cs_end();
      wait_clk(H);
      cs_n = 1'b1;
      wait_clk(2 * H);
   endtask

   task automatic send(input logic [7:0] tx);
      logic [7:0] rx;
      spi_byte(tx, rx);
   endtask

   function automatic logic [7:0] wdat(input int seed, input int k);
      return 8'((seed + k * 29) & 8'hFF);
   endfunction

   // R7 R8 R9: page write burst with bench-side image update
   task automatic wr_burst(input logic [15:0] a, input int n, input int seed);
      int pw0;
      pw0 = n_pw;
      cs_begin();
      send(8'h02);
      send(a[15:8]);
      send(a[7:0]);
      for (int k = 0; k < n; k++) begin
         int ad;
         send(wdat(seed, k));
         ad = (int'(a) & (DEPTH - (1 << PW))) | ((int'(a) + k) & ((1 << PW) - 1));
         if (wr_ok) exp_mem[ad] = wdat(seed, k);
      end
      cs_end();
      chk(n_pw == pw0 + n, "R7 write strobe count", n_pw - pw0, n);
   endtask

   // R6: read burst compared against image, wrapping over the array
   task automatic rd_burst(input logic [15:0] a, input int n, input logic [7:0] op);
      logic [7:0] rx;
      int bad;
      bad = 0;
      cs_begin();
      send(op);
      send(a[15:8]);
      send(a[7:0]);
      for (int k = 0; k < n; k++) begin
         int ad;
         ad = (int'(a) + k) % DEPTH;
         spi_byte(8'h00, rx);
         if (rx !== exp_mem[ad]) begin
            bad++;
            chk(1'b0, "R6 read byte", int'(rx), int'(exp_mem[ad]));
         end
         if (k == 0) chk(so_oe === 1'b1, "R2 so_oe during read", int'(so_oe), 1);
      end
      cs_end();
      chk(bad == 0, "R6 read burst", bad, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      logic [7:0] rx;
      int s0;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);

      // R1 reset state
      chk(so_oe === 1'b0, "R1 reset so_oe", int'(so_oe), 0);
      chk(n_set + n_clr + n_sr + n_pw == 0, "R1 reset strobes", n_set + n_clr + n_sr + n_pw, 0);

      // R3 latch set with bit 3 clear and set, latch clear
      cs_begin(); send(8'h06); cs_end();
      cs_begin(); send(8'h0E); cs_end();
      chk(n_set == 2, "R3 set strobe", n_set, 2);
      cs_begin(); send(8'h04); cs_end();
      chk(n_clr == 1, "R3 clear strobe", n_clr, 1);

      // R4 status read, MSB first, re-sampled at byte boundary
      status_in = 8'h01;
      cs_begin();
      send(8'h05);
      status_in = 8'hC3;
      spi_byte(8'h00, rx);
      chk(rx == 8'h01, "R4 status byte 1", int'(rx), 8'h01);
      chk(so_oe === 1'b1, "R2 so_oe status read", int'(so_oe), 1);
      spi_byte(8'h00, rx);
      chk(rx == 8'hC3, "R4 status byte 2", int'(rx), 8'hC3);
      cs_end();
      chk(so_oe === 1'b0, "R1 so_oe after deselect", int'(so_oe), 0);

      // R5 status write
      cs_begin(); send(8'h09); send(8'h8C); cs_end();
      chk(n_sr == 1 && last_sr == 8'h8C, "R5 status write", int'(last_sr), 8'h8C);

      // R7 fill whole array, one page per burst, high address bits don't-care
      wr_ok = 1'b1;
      for (int p = 0; p < DEPTH / (1 << PW); p++)
         wr_burst(16'hFFC0 | 16'(p * (1 << PW)), 1 << PW, p * 13 + 5);

      // R6 read everything with bit 3 set, continuing past the top
      rd_burst(16'h0000, DEPTH + 3, 8'h0B);

      // R8 page overrun: 10 bytes starting at offset 6 of page 1
      wr_burst(16'h000E, 10, 77);
      rd_burst(16'h0008, 9, 8'h03);

      // R9 write with grant low leaves content unchanged
      wr_ok = 1'b0;
      wr_burst(16'h0014, 2, 200);
      wr_ok = 1'b1;
      rd_burst(16'h0012, 6, 8'h03);

      // R6 wrap from top address back to 0
      rd_burst(16'h003E, 4, 8'h03);

      // R10 invalid opcodes silence the selection
      s0 = n_set;
      oe_seen = 1'b0;
      cs_begin(); send(8'h07); send(8'h06); send(8'h03); send(8'h00); cs_end();
      cs_begin(); send(8'h16); send(8'h05); send(8'h00); cs_end();
      chk(n_set == s0, "R10 no strobe after invalid", n_set, s0);
      chk(oe_seen == 1'b0, "R10 so_oe stays off", int'(oe_seen), 0);
      cs_begin(); send(8'h06); cs_end();
      chk(n_set == s0 + 1, "R10 recovery on next select", n_set, s0 + 1);

      // R11 hold in the middle of a read burst
      cs_begin();
      send(8'h03); send(8'h00); send(8'h10);
      spi_byte(8'h00, rx);
      chk(rx == exp_mem[16], "R11 byte before hold", int'(rx), int'(exp_mem[16]));
      hold_n = 1'b0;
      wait_clk(H);
      chk(so_oe === 1'b0, "R11 so_oe off in hold", int'(so_oe), 0);
      for (int t = 0; t < 3; t++) begin
         si = ~si;
         sck = 1'b1; wait_clk(H);
         sck = 1'b0; wait_clk(H);
      end
      chk(so_oe === 1'b0, "R11 so_oe off while clocked in hold", int'(so_oe), 0);
      hold_n = 1'b1;
      wait_clk(H);
      spi_byte(8'h00, rx);
      chk(rx == exp_mem[17], "R11 byte after resume", int'(rx), int'(exp_mem[17]));
      spi_byte(8'h00, rx);
      chk(rx == exp_mem[18], "R11 second byte after resume", int'(rx), int'(exp_mem[18]));
      cs_end();

      // R12 strobe totals consistent (exclusivity also asserted in RTL)
      chk(n_clr == 1 && n_sr == 1, "R12 strobe totals", n_clr + n_sr, 2);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule